// File: doc/BRIEF.md
# RS-485 Transceiver Direction Controller

This block sits beside a 16550-style UART and decides, cycle by cycle, whether an attached RS-422/RS-485 transceiver drives the bus, listens to it, or does both. Software programs a single byte-wide control register at one address. That register holds four things:

- a two-bit wire mode;
- a master enable for the transceiver;
- a bus termination enable;
- reserved bits that always read as zero.

The UART supplies three status inputs to the block:

- its DTR modem output;
- a flag that is high while the transmit FIFO holds data;
- a flag that is high while the transmit shift register is still sending a character, up to and including its stop bit.

There are four wire modes:

- Full duplex keeps both the driver and the receiver on.
- Echo gates the driver with DTR and leaves the receiver on.
- DTR-gated mode gates the driver with DTR and turns the receiver off while the driver is on.
- Automatic mode turns the driver on while transmit data is pending or still shifting out, and turns the receiver off for that time.

Driver-enable and receiver-enable are registered, so a register write or an input change reaches the pins one clock later and never glitches within a cycle. The termination output follows its control bit directly.

Top module: `rs485_txvr_ctrl`

## Requirements
- R1: After reset the control register reads 0x03 (automatic mode, master enable clear, termination clear), drv_en is 0, rcv_en_n is 1 and term_en is 0.
- R2: A write at address CTRL_OFFSET stores bits [1:0] (mode), bit 3 (enable) and bit 6 (termination). Bits 2, 4, 5 and 7 read as zero. A write at any other address changes nothing, and a read at any other address returns 0.
- R3: While bit 3 is clear, drv_en is 0 and rcv_en_n is 1 whatever the mode and the inputs.
- R4: In mode 0 (full duplex) with enable set, drv_en is 1 and rcv_en_n is 0, independent of dtr.
- R5: In mode 1 (echo) with enable set, drv_en equals dtr and rcv_en_n is 0.
- R6: In mode 2 (DTR-gated) with enable set, drv_en equals dtr and rcv_en_n equals dtr.
- R7: In mode 3 (automatic) with enable set, drv_en is 1 when txfifo_nonempty or tx_busy is high, and rcv_en_n equals drv_en.
- R8: In mode 3, drv_en stays 1 while tx_busy is high after txfifo_nonempty has fallen, so the last stop bit is driven.
- R9: term_en equals control bit 6 from the clock edge that writes it, regardless of bit 3.
- R10: drv_en and rcv_en_n change only at a clock edge and reflect the control register and inputs sampled at the previous edge (one cycle of latency).
- R11: In modes 2 and 3 the driver and the receiver are never enabled together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| dtr | input | 1 | DTR output of the UART, active high |
| txfifo_nonempty | input | 1 | Transmit FIFO holds data |
| tx_busy | input | 1 | Transmit shift register active through the stop bit |
| drv_en | output | 1 | Transceiver driver enable, active high |
| rcv_en_n | output | 1 | Transceiver receiver enable, active low |
| term_en | output | 1 | Bus termination enable |

## Verification
The bench builds the block with ADDR_W of 4 and the control register at offset 15. This leaves fifteen other addresses that the bench uses to show that writes elsewhere are dropped and that reads elsewhere return zero. Every mode is driven with both DTR levels, and automatic mode is also driven with the FIFO flag and the busy flag each high alone. One check samples drv_en between the input change and the next edge to confirm the single-cycle latency.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  typedef enum logic [1:0] {
    WM_FULL_DUPLEX = 2'd0,
    WM_ECHO        = 2'd1,
    WM_DTR_GATED   = 2'd2,
    WM_AUTO        = 2'd3
  } wire_mode_e;

  localparam int CTRL_W      = 8;
  localparam int EN_BIT      = 3;
  localparam int TERM_BIT    = 6;
  localparam logic [CTRL_W-1:0] CTRL_WR_MASK = 8'h4B;
  localparam logic [CTRL_W-1:0] CTRL_RST_VAL = 8'h03;
endpackage

// File: rtl/rs485_ctrl_reg.sv
module rs485_ctrl_reg
  import rs485_dir_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int CTRL_OFFSET = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] rdata,
  output logic [CTRL_W-1:0] ctrl_q
);
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(CTRL_OFFSET);

  logic hit;
  assign hit = (addr == SEL_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST_VAL;
    end else if (wr_en && hit) begin
      ctrl_q <= wdata & CTRL_WR_MASK;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) rdata = ctrl_q;
  end
endmodule

// File: rtl/rs485_dir_logic.sv
module rs485_dir_logic
  import rs485_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  wire_mode_e mode,
  input  logic       master_en,
  input  logic       dtr,
  input  logic       fifo_ne,
  input  logic       busy,
  output logic       de_q,
  output logic       re_n_q
);
  logic drv_nxt;
  logic rx_nxt;

  always_comb begin
    drv_nxt = 1'b0;
    rx_nxt  = 1'b0;
    unique case (mode)
      WM_FULL_DUPLEX: begin drv_nxt = 1'b1; rx_nxt = 1'b1; end
      WM_ECHO:        begin drv_nxt = dtr;  rx_nxt = 1'b1; end
      WM_DTR_GATED:   begin drv_nxt = dtr;  rx_nxt = !dtr; end
      WM_AUTO: begin
        drv_nxt = fifo_ne || busy;
        rx_nxt  = !(fifo_ne || busy);
      end
      default:        begin drv_nxt = 1'b0; rx_nxt = 1'b0; end
    endcase
    if (!master_en) begin
      drv_nxt = 1'b0;
      rx_nxt  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      de_q   <= 1'b0;
      re_n_q <= 1'b1;
    end else begin
      de_q   <= drv_nxt;
      re_n_q <= !rx_nxt;
    end
  end
endmodule

// File: rtl/rs485_txvr_ctrl.sv
module rs485_txvr_ctrl
  import rs485_dir_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int CTRL_OFFSET = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              dtr,
  input  logic              txfifo_nonempty,
  input  logic              tx_busy,
  output logic              drv_en,
  output logic              rcv_en_n,
  output logic              term_en
);
  logic [CTRL_W-1:0] ctrl_q;

  rs485_ctrl_reg #(
    .ADDR_W     (ADDR_W),
    .CTRL_OFFSET(CTRL_OFFSET)
  ) u_reg (
    .clk   (clk),
    .rst   (rst),
    .addr  (reg_addr),
    .wr_en (reg_wr_en),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .ctrl_q(ctrl_q)
  );

  rs485_dir_logic u_dir (
    .clk      (clk),
    .rst      (rst),
    .mode     (wire_mode_e'(ctrl_q[1:0])),
    .master_en(ctrl_q[EN_BIT]),
    .dtr      (dtr),
    .fifo_ne  (txfifo_nonempty),
    .busy     (tx_busy),
    .de_q     (drv_en),
    .re_n_q   (rcv_en_n)
  );

  assign term_en = ctrl_q[TERM_BIT];
endmodule

// File: rtl/rs485_txvr_chk.sv
module rs485_txvr_chk #(
  parameter int ADDR_W      = 4,
  parameter int CTRL_OFFSET = 15
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr_en,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic [7:0]        ctrl_q,
  input logic              dtr,
  input logic              txfifo_nonempty,
  input logic              tx_busy,
  input logic              drv_en,
  input logic              rcv_en_n,
  input logic              term_en
);
  logic hit;
  assign hit = (reg_addr == ADDR_W'(CTRL_OFFSET));

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    hit |-> (reg_rdata[2] == 1'b0 && reg_rdata[5:4] == 2'b00 && reg_rdata[7] == 1'b0)); // R2
  AST_FOREIGN_READ: assert property (@(posedge clk) disable iff (rst)
    !hit |-> reg_rdata == 8'h00); // R2
  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[3] |=> (!drv_en && rcv_en_n)); // R3
  AST_FULL_DUPLEX: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[3] && ctrl_q[1:0] == 2'd0) |=> (drv_en && !rcv_en_n)); // R4
  AST_ECHO: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[3] && ctrl_q[1:0] == 2'd1) |=> (drv_en == $past(dtr) && !rcv_en_n)); // R5
  AST_DTR_GATED: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[3] && ctrl_q[1:0] == 2'd2) |=> (drv_en == $past(dtr) && rcv_en_n == $past(dtr))); // R6
  AST_AUTO_DIR: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[3] && ctrl_q[1:0] == 2'd3) |=>
      (drv_en == $past(txfifo_nonempty || tx_busy) && rcv_en_n == drv_en)); // R7
  AST_STOP_BIT_HELD: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[3] && ctrl_q[1:0] == 2'd3 && tx_busy) |=> drv_en); // R8
  AST_TERM_WRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && hit) |=> term_en == $past(reg_wdata[6])); // R9
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[3] && ctrl_q[1]) |=> !(drv_en && !rcv_en_n)); // R11
endmodule

bind rs485_txvr_ctrl rs485_txvr_chk #(
  .ADDR_W     (ADDR_W),
  .CTRL_OFFSET(CTRL_OFFSET)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .reg_addr       (reg_addr),
  .reg_wr_en      (reg_wr_en),
  .reg_wdata      (reg_wdata),
  .reg_rdata      (reg_rdata),
  .ctrl_q         (ctrl_q),
  .dtr            (dtr),
  .txfifo_nonempty(txfifo_nonempty),
  .tx_busy        (tx_busy),
  .drv_en         (drv_en),
  .rcv_en_n       (rcv_en_n),
  .term_en        (term_en)
);

// File: tb/tb_rs485_txvr_ctrl.sv
`timescale 1ns/1ps
module tb_rs485_txvr_ctrl;
  localparam int ADDR_W = 4;
  localparam int OFF    = 15;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic              reg_wr_en = 1'b0;
  logic [7:0]        reg_wdata = '0;
  logic [7:0]        reg_rdata;
  logic              dtr = 1'b0;
  logic              txfifo_nonempty = 1'b0;
  logic              tx_busy = 1'b0;
  logic              drv_en;
  logic              rcv_en_n;
  logic              term_en;

  always #4 clk = ~clk;

  rs485_txvr_ctrl #(.ADDR_W(ADDR_W), .CTRL_OFFSET(OFF)) dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dtr(dtr),
    .txfifo_nonempty(txfifo_nonempty), .tx_busy(tx_busy),
    .drv_en(drv_en), .rcv_en_n(rcv_en_n), .term_en(term_en)
  );

  typedef struct {
    logic  de;
    logic  ren;
    logic  term;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares outputs shortly after each edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, {5'b0, drv_en, rcv_en_n, term_en}, {5'b0, e.de, e.ren, e.term});
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = ADDR_W'(OFF);
  endtask

  task automatic rd_check(input string tag, input logic [ADDR_W-1:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
    reg_addr = ADDR_W'(OFF);
  endtask

  // Driver: sets inputs and queues the outputs expected after the next edge
  task automatic apply(input string tag, input logic d, input logic f, input logic b,
                       input logic ede, input logic eren, input logic eterm);
    exp_t e;
    @(negedge clk);
    dtr = d; txfifo_nonempty = f; tx_busy = b;
    e.de = ede; e.ren = eren; e.term = eterm; e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    reg_addr = ADDR_W'(OFF);
    #1;
    check("R1 reset reg", reg_rdata, 8'h03);
    check("R1 reset pins", {5'b0, drv_en, rcv_en_n, term_en}, 8'h02);

    // disabled, auto mode: data pending must not turn driver on
    apply("R3 disabled auto", 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);

    wr(ADDR_W'(OFF), 8'hFF);
    rd_check("R2 masked readback", ADDR_W'(OFF), 8'h4B);
    wr(ADDR_W'(3), 8'h00);
    rd_check("R2 foreign write ignored", ADDR_W'(OFF), 8'h4B);
    rd_check("R2 foreign read zero", ADDR_W'(3), 8'h00);

    apply("R9 term set", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    apply("R7 auto fifo", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    apply("R8 auto busy after fifo empty", 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    apply("R7 auto idle", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

    wr(ADDR_W'(OFF), 8'h08);
    apply("R4 duplex dtr0", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    apply("R4 duplex dtr1", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);

    wr(ADDR_W'(OFF), 8'h09);
    apply("R5 echo dtr1", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    apply("R5 echo dtr0", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);

    wr(ADDR_W'(OFF), 8'h0A);
    apply("R6 dtr-gated dtr1", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    apply("R6 dtr-gated dtr0", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    // R10: input change is not visible before the next edge
    dtr = 1'b1;
    #1;
    check("R10 no change before edge", {7'b0, drv_en}, 8'h00);
    @(posedge clk); #2;
    check("R10 change after edge", {7'b0, drv_en}, 8'h01);

    wr(ADDR_W'(OFF), 8'h42);
    apply("R3 disabled dtr-gated term kept", 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    apply("R9 term independent of enable", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule